// File: doc/BRIEF.md
# Memory-Mapped Accumulator Arithmetic Unit

This block is a bus peripheral for a machine whose only instruction moves one word from one address to another. It sits in a window of eight consecutive word addresses just below the topmost address, which the processor keeps for its program counter. Writing a word into the window either loads the internal accumulator or combines the word with it. Reading from the window returns the accumulator, or a Boolean value built from the condition flags the last write left behind.

The same address has two meanings. On a write, its offset selects the operation. On a read, its offset selects the accumulator or a condition. A true condition reads as 2 and a false one reads as 0. Because an instruction is two words long, adding the Boolean to a jump target steps over exactly one instruction, and this gives the program its conditional branch. Read data is combinational. Writes take effect at the next rising clock edge.

Top module: `mau_top`

## Requirements
- R1: The window is the eight addresses from (2^ADDR_W − 16) to (2^ADDR_W − 9), which is 0xFFF0 to 0xFFF7 at the default width. The offset is addr[2:0]. A write to any other address leaves the accumulator and flags unchanged. A read from any other address returns 0.
- R2: A write to offset 0 loads the accumulator with the write data. A read from offset 0 returns the accumulator.
- R3: Writes to offsets 1, 2 and 3 set the accumulator to acc−data, data−acc and data+acc, all modulo 2^DATA_W.
- R4: Writes to offsets 4, 5 and 6 set the accumulator to data XOR acc, data AND acc and data OR acc. A write to offset 7 sets it to data shifted right by one with a zero fill.
- R5: Every write inside the window sets N to the sign bit of the new accumulator and sets Z when the new accumulator is zero.
- R6: Add and both subtracts set O on two's-complement overflow. They set C to the carry out of the sign bit. A subtract is done as the minuend plus the inverted subtrahend plus one, so C=1 means no borrow.
- R7: The load and the three logical operations clear O and C. The right shift clears O and sets C to the bit shifted out, data[0].
- R8: Reads from offsets 1 to 7 select, in order: N, Z, O, C, N^O, (N^O)|Z, and C^~Z.
- R9: A condition read returns 2 when the condition is true and 0 when it is false. When the read strobe is low, read data is 0.
- R10: A synchronous active-high reset clears the accumulator and all four flags.
- R11: Read data is valid in the same cycle as the read strobe. A read never changes the accumulator or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (combinational) |

## Verification
Every piece of state in this block is visible at the ports in the cycle after it is written. The accumulator reads back at offset 0, and each flag, or a combination of flags, reads back at one of offsets 1 to 7. A wrong result or a wrong flag therefore shows as a mismatch one clock after the faulty write. To catch it, the bench reads all eight offsets after every operation, over a grid of operand pairs chosen at the sign, carry and zero boundaries. It also writes and reads just outside the window, so a decode that is off by one shows up at once as a changed accumulator or nonzero read data.

// File: rtl/mau_pkg.sv
package mau_pkg;

    localparam int WIN_WORDS = 8;
    localparam int OFS_W     = $clog2(WIN_WORDS);
    localparam int TRUE_CODE = 2;

    typedef enum logic [OFS_W-1:0] {
        OP_LOAD = 3'd0,
        OP_SUBD = 3'd1,
        OP_SUBA = 3'd2,
        OP_ADD  = 3'd3,
        OP_XOR  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_SHR  = 3'd7
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic o;
        logic c;
    } flags_t;

    function automatic logic signed_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
        return (a_msb == b_msb) && (r_msb != a_msb);
    endfunction

endpackage

// File: rtl/mau_decode.sv
module mau_decode
    import mau_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    localparam logic [ADDR_W-1:0] WIN_BASE = ~ADDR_W'(15);

    always_comb begin
        hit = (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
        ofs = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/mau_alu.sv
module mau_alu
    import mau_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] res,
    output flags_t            flg
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opa, opb;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic              arith;

    always_comb begin
        opa   = data;
        opb   = acc;
        cin   = 1'b0;
        arith = 1'b0;
        unique case (op)
            OP_SUBD: begin opa = acc;  opb = ~data; cin = 1'b1; arith = 1'b1; end
            OP_SUBA: begin opa = data; opb = ~acc;  cin = 1'b1; arith = 1'b1; end
            OP_ADD:  begin arith = 1'b1; end
            default: ;
        endcase
        sum = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
    end

    always_comb begin
        flg = '0;
        unique case (op)
            OP_LOAD: res = data;
            OP_XOR:  res = data ^ acc;
            OP_AND:  res = data & acc;
            OP_OR:   res = data | acc;
            OP_SHR:  res = data >> 1;
            default: res = sum[DATA_W-1:0];
        endcase
        if (arith) begin
            flg.c = sum[DATA_W];
            flg.o = signed_ovf(opa[MSB], opb[MSB], res[MSB]);
        end else if (op == OP_SHR) begin
            flg.c = data[0];
        end
        flg.n = res[MSB];
        flg.z = (res == '0);
    end
endmodule

// File: rtl/mau_cond.sv
module mau_cond
    import mau_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  flags_t            flg,
    input  logic [OFS_W-1:0]  sel,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] word
);
    logic [WIN_WORDS-1:0] cond_vec;

    always_comb begin
        cond_vec[0] = 1'b0;
        cond_vec[1] = flg.n;
        cond_vec[2] = flg.z;
        cond_vec[3] = flg.o;
        cond_vec[4] = flg.c;
        cond_vec[5] = flg.n ^ flg.o;
        cond_vec[6] = (flg.n ^ flg.o) | flg.z;
        cond_vec[7] = flg.c ^ ~flg.z;
    end

    always_comb begin
        if (sel == '0)
            word = acc;
        else
            word = cond_vec[sel] ? DATA_W'(TRUE_CODE) : '0;
    end
endmodule

// File: rtl/mau_top.sv
module mau_top
    import mau_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              hit;
    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] acc_q, alu_res, sel_word;
    flags_t            flg_q, alu_flg;

    mau_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hit  (hit),
        .ofs  (ofs)
    );

    mau_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (op_e'(ofs)),
        .acc  (acc_q),
        .data (wdata),
        .res  (alu_res),
        .flg  (alu_flg)
    );

    mau_cond #(.DATA_W(DATA_W)) u_cond (
        .flg  (flg_q),
        .sel  (ofs),
        .acc  (acc_q),
        .word (sel_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            flg_q <= '0;
        end else if (wr_en && hit) begin
            acc_q <= alu_res;
            flg_q <= alu_flg;
        end
    end

    always_comb begin
        rdata = (rd_en && hit) ? sel_word : '0;
    end

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && hit)) |=> ($stable(acc_q) && $stable(flg_q))); // R1
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |-> (rdata == '0)); // R1
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit && ofs == '0) |=> (acc_q == $past(wdata))); // R2
    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (flg_q.z == (acc_q == '0) && flg_q.n == acc_q[DATA_W-1])); // R5
    AST_LOGIC_CLEAR_OC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit && (ofs == 3'd0 || ofs == 3'd4 || ofs == 3'd5 || ofs == 3'd6))
        |=> (!flg_q.o && !flg_q.c)); // R7
    AST_BOOL_CODE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit && ofs != '0) |-> (rdata == '0 || rdata == DATA_W'(TRUE_CODE))); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |-> (rdata == '0)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && flg_q == '0)); // R10
endmodule

// File: tb/mau_top_tb.sv
module mau_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m_acc;
    logic m_n, m_z, m_o, m_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    mau_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [DW-1:0] pat(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'h5555;
            7: return 16'hAAAA;
            default: return 16'h8001;
        endcase
    endfunction

    // reference model of R2..R7
    task automatic model_write(input int op, input logic [DW-1:0] d);
        logic [DW:0] s;
        logic [DW-1:0] a, r;
        a = m_acc; m_o = 0; m_c = 0; s = '0;
        case (op)
            0: r = d;
            1: begin s = {1'b0,a} + {1'b0,~d} + 17'd1; r = s[DW-1:0]; m_c = s[DW];
                     m_o = (a[15] != d[15]) && (r[15] != a[15]); end
            2: begin s = {1'b0,d} + {1'b0,~a} + 17'd1; r = s[DW-1:0]; m_c = s[DW];
                     m_o = (a[15] != d[15]) && (r[15] != d[15]); end
            3: begin s = {1'b0,a} + {1'b0,d}; r = s[DW-1:0]; m_c = s[DW];
                     m_o = (a[15] == d[15]) && (r[15] != a[15]); end
            4: r = a ^ d;
            5: r = a & d;
            6: r = a | d;
            default: begin r = d >> 1; m_c = d[0]; end
        endcase
        m_acc = r; m_n = r[15]; m_z = (r == 0);
    endtask

    function automatic logic [DW-1:0] model_read(input int k);
        logic b;
        case (k)
            1: b = m_n;
            2: b = m_z;
            3: b = m_o;
            4: b = m_c;
            5: b = m_n ^ m_o;
            6: b = (m_n ^ m_o) | m_z;
            7: b = m_c ^ ~m_z;
            default: return m_acc;
        endcase
        return b ? 16'd2 : 16'd0;
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [DW-1:0] exp, input logic [DW-1:0] act);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // read all eight offsets in one cycle each; combinational per R11
    task automatic read_all(input string tag);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            addr = 16'hFFF0 + 16'(k); rd_en = 1'b1;
            #1;
            check(tag, model_read(k), rdata);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_acc = 0; m_n = 0; m_z = 0; m_o = 0; m_c = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state, all flags cleared (so C^~Z reads true)
        read_all("R10 reset");
        // R9: idle strobe reads zero
        @(negedge clk); addr = 16'hFFF7; #1;
        check("R9 idle", 16'h0, rdata);

        // R2 R3 R4 R5 R6 R7 R8 R9: operand grid per operation
        for (int op = 1; op < 8; op++) begin
            for (int i = 0; i < 9; i++) begin
                for (int j = 0; j < 9; j++) begin
                    bus_write(16'hFFF0, pat(i)); model_write(0, pat(i));
                    bus_write(16'hFFF0 + 16'(op), pat(j)); model_write(op, pat(j));
                    read_all($sformatf("R3_R4_R6_R7_R8 op%0d", op));
                end
            end
        end
        // R2 R5 R7: load after an arithmetic op clears O and C
        bus_write(16'hFFF0, 16'h7FFF); model_write(0, 16'h7FFF);
        bus_write(16'hFFF3, 16'h0001); model_write(3, 16'h0001);
        bus_write(16'hFFF0, 16'h0000); model_write(0, 16'h0000);
        read_all("R2 load");

        // R1: writes just outside the window have no effect
        bus_write(16'hFFF0, 16'h00A5); model_write(0, 16'h00A5);
        bus_write(16'hFFEF, 16'h1111);
        bus_write(16'hFFF8, 16'h2222);
        bus_write(16'hFFFF, 16'h3333);
        bus_write(16'h0000, 16'h4444);
        read_all("R1 miss write");
        // R1: reads outside return 0
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            addr = (k == 0) ? 16'hFFEF : (k == 1) ? 16'hFFF8 : (k == 2) ? 16'hFFFF : 16'h0000;
            rd_en = 1'b1; #1;
            check("R1 miss read", 16'h0, rdata);
        end
        // R11: read held over several cycles leaves state untouched
        @(negedge clk); addr = 16'hFFF0; rd_en = 1'b1;
        repeat (3) @(negedge clk);
        #1; check("R11 read no effect", 16'h00A5, rdata);
        rd_en = 1'b0;

        // R10: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_acc = 0; m_n = 0; m_z = 0; m_o = 0; m_c = 0;
        read_all("R10 rerun");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule